// File: doc/BRIEF.md
# Two-Lane to One-Lane GMII Transmit Serializer

This block sits between a MAC that produces a 16-bit transmit word per clock and a byte-wide GMII transmit path running at twice that byte rate. Every input word holds two byte lanes, each with its own enable bit and its own error bit. The block sends the lanes one at a time, low lane first. The error bit of each lane travels with that lane's byte.

A lane whose enable is low is dropped. This lets a frame end on the low lane of its last word. A ready output pauses the MAC for one cycle after it accepts a word with both lanes enabled, while the upper byte is sent. A word that produces a single byte does not pause the MAC. An input word with both enables low produces one idle cycle on the byte side, and that idle cycle marks the frame boundary.

The input side is sampled on every rising clock edge where the ready output is high. The byte side is registered.

Top module: `gmii_lane_serializer`

## Requirements
- R1: For an accepted word with in_en = 2'b11, out_d shows in_d[7:0] one cycle after the accepting edge and in_d[15:8] one cycle after that, with out_en high in both cycles.
- R2: An accepted word with in_en = 2'b01 produces exactly one output byte, in_d[7:0]. The upper lane is never emitted.
- R3: An accepted word with in_en = 2'b10 produces exactly one output byte, in_d[15:8].
- R4: out_er for each emitted byte equals the error bit of that byte's lane: in_er[0] for in_d[7:0] and in_er[1] for in_d[15:8].
- R5: in_rdy is low only in the cycle right after a two-lane word is accepted. An input word presented while in_rdy is low is ignored.
- R6: When words are supplied back to back, out_en stays high with no gaps. A single-lane word lets the next word be accepted in the very next cycle.
- R7: An accepted word with in_en = 2'b00 makes out_en and out_er low in the following cycle. This is the frame boundary on the byte side.
- R8: The first byte of an accepted word appears on the outputs exactly one clock after the accepting edge.
- R9: A synchronous active-low reset (rst_n = 0 at a rising edge) clears out_en and out_er, sets in_rdy high and discards any pending upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| in_d | input | 16 | Two-lane data word, lane 0 in bits [7:0] |
| in_en | input | 2 | Per-lane enable, bit 0 for lane 0 |
| in_er | input | 2 | Per-lane error flag, bit 0 for lane 0 |
| in_rdy | output | 1 | High when the word on the input is taken at the next edge |
| out_d | output | 8 | Serialized data byte |
| out_en | output | 1 | Byte on out_d is valid |
| out_er | output | 1 | Error flag of the byte on out_d |

## Verification
The only state in the block is the pending upper-lane byte and its valid flag. A fault there shows at the ports within two cycles of any two-lane word. A stuck valid flag holds in_rdy low and repeats or loses bytes. A wrong captured value gives a wrong second byte or a misplaced error flag. A lane-selection fault shows one cycle after acceptance as the wrong byte first. A missing pause shows as a lost upper byte, which the cycle-exact traces of the output stream catch.

// File: rtl/gmii_ser_pkg.sv
// Shared constants and lane record for the two-lane GMII serializer.
// Assumes two byte lanes per input word, lane 0 transmitted first.
package gmii_ser_pkg;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = 2;
    localparam int unsigned WORD_W = LANE_W * LANES;

    // One byte lane with its error flag
    typedef struct packed {
        logic              er;
        logic [LANE_W-1:0] d;
    } lane_t;
endpackage

// File: rtl/ser_lane_pick.sv
// Splits an input word into lanes and decides which lane goes out first
// and whether a second lane must be held for the following cycle.
// Assumes lane 0 has priority; a word with only lane 1 enabled sends lane 1.
module ser_lane_pick
    import gmii_ser_pkg::*;
(
    input  logic [WORD_W-1:0] word_d,
    input  logic [LANES-1:0]  word_en,
    input  logic [LANES-1:0]  word_er,
    output logic              first_vld,
    output lane_t             first_lane,
    output logic              second_vld,
    output lane_t             second_lane
);
    lane_t lanes [LANES];

    // Unpack each byte lane with its own error bit
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_unpack
            assign lanes[g].d  = word_d[g*LANE_W +: LANE_W];
            assign lanes[g].er = word_er[g];
        end
    endgenerate

    // Lower lane first; the upper lane is held only when both are enabled
    always_comb begin
        first_vld   = |word_en;
        second_vld  = &word_en;
        first_lane  = word_en[0] ? lanes[0] : lanes[1];
        second_lane = lanes[1];
    end
endmodule

// File: rtl/ser_pend_reg.sv
// Holds the upper-lane byte for the one cycle between the two halves
// of a two-lane word. Assumes it is only loaded while empty.
module ser_pend_reg
    import gmii_ser_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  lane_t load_lane,
    output logic  pend_vld,
    output lane_t pend_lane
);
    // Capture on load; the held byte always drains in the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_lane <= '0;
        end else begin
            pend_vld <= load;
            if (load) begin
                pend_lane <= load_lane;
            end
        end
    end
endmodule

// File: rtl/ser_out_reg.sv
// Registers the byte-side outputs. Data and error are zeroed in idle
// cycles so a gap never carries a stale error flag.
module ser_out_reg
    import gmii_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nxt_en,
    input  lane_t             nxt_lane,
    output logic [LANE_W-1:0] out_d,
    output logic              out_en,
    output logic              out_er
);
    // Register the selected byte, or an idle cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en <= 1'b0;
            out_er <= 1'b0;
            out_d  <= '0;
        end else begin
            out_en <= nxt_en;
            out_er <= nxt_en & nxt_lane.er;
            out_d  <= nxt_en ? nxt_lane.d : '0;
        end
    end
endmodule

// File: rtl/gmii_lane_serializer.sv
// Top of the two-lane to one-lane GMII transmit serializer.
// Takes a word whenever in_rdy is high, sends lane 0 then lane 1 and
// drops disabled lanes. Assumes one clock for both sides, with the
// byte rate twice the word rate on average.
module gmii_lane_serializer
    import gmii_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_d,
    input  logic [LANES-1:0]  in_en,
    input  logic [LANES-1:0]  in_er,
    output logic              in_rdy,
    output logic [LANE_W-1:0] out_d,
    output logic              out_en,
    output logic              out_er
);
    logic  first_vld, second_vld, pend_vld, load, nxt_en;
    lane_t first_lane, second_lane, pend_lane, nxt_lane;

    ser_lane_pick u_pick (
        .word_d      (in_d),
        .word_en     (in_en),
        .word_er     (in_er),
        .first_vld   (first_vld),
        .first_lane  (first_lane),
        .second_vld  (second_vld),
        .second_lane (second_lane)
    );

    ser_pend_reg u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_lane (second_lane),
        .pend_vld  (pend_vld),
        .pend_lane (pend_lane)
    );

    // A held upper byte blocks new input for one cycle
    assign in_rdy = !pend_vld;

    // Choose the held byte if any, else the first lane of the input word
    always_comb begin
        if (pend_vld) begin
            nxt_en   = 1'b1;
            nxt_lane = pend_lane;
            load     = 1'b0;
        end else begin
            nxt_en   = first_vld;
            nxt_lane = first_lane;
            load     = second_vld;
        end
    end

    ser_out_reg u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_en   (nxt_en),
        .nxt_lane (nxt_lane),
        .out_d    (out_d),
        .out_en   (out_en),
        .out_er   (out_er)
    );
endmodule

// File: rtl/ser_chk.sv
// Port-level properties of the serializer, bound to the top module.
module ser_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] in_d,
    input logic [1:0]  in_en,
    input logic [1:0]  in_er,
    input logic        in_rdy,
    input logic [7:0]  out_d,
    input logic        out_en,
    input logic        out_er
);
    // R1
    lane0_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rdy && in_en == 2'b11) |=> (out_en && out_d == $past(in_d[7:0])));

    // R1
    lane1_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rdy && in_en == 2'b11) |-> ##2 (out_en && out_d == $past(in_d[15:8], 2)
                                            && out_er == $past(in_er[1], 2)));

    // R4
    lane0_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rdy && in_en[0]) |=> (out_er == $past(in_er[0])));

    // R5
    stall_after_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rdy && in_en == 2'b11) |=> !in_rdy);

    // R5
    stall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_rdy |=> in_rdy);

    // R7
    idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rdy && in_en == 2'b00) |=> (!out_en && !out_er));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_en && !out_er && in_rdy));
endmodule

bind gmii_lane_serializer ser_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_d   (in_d),
    .in_en  (in_en),
    .in_er  (in_er),
    .in_rdy (in_rdy),
    .out_d  (out_d),
    .out_en (out_en),
    .out_er (out_er)
);

// File: tb/gmii_lane_serializer_tb_top.sv
// Directed bench: each scenario task drives words, builds the expected
// per-cycle output trace and compares it with the recorded trace.
module gmii_lane_serializer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_d = '0;
    logic [1:0]  in_en = '0;
    logic [1:0]  in_er = '0;
    logic        in_rdy;
    logic [7:0]  out_d;
    logic        out_en;
    logic        out_er;

    int checks = 0;
    int errors = 0;
    bit rec = 1'b0;
    bit done = 1'b0;
    logic [9:0] trace [$];
    logic [9:0] expq  [$];

    always #4 clk = ~clk;

    gmii_lane_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .in_d(in_d), .in_en(in_en), .in_er(in_er),
        .in_rdy(in_rdy), .out_d(out_d), .out_en(out_en), .out_er(out_er)
    );

    // Record one entry per cycle: {en, er, data}, data masked in idle
    always @(posedge clk) begin
        #1;
        if (rec) trace.push_back({out_en, out_er, out_en ? out_d : 8'h00});
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected output trace for one accepted word
    task automatic model(input logic [15:0] d, input logic [1:0] en, input logic [1:0] er);
        case (en)
            2'b11: begin
                expq.push_back({1'b1, er[0], d[7:0]});
                expq.push_back({1'b1, er[1], d[15:8]});
            end
            2'b01: expq.push_back({1'b1, er[0], d[7:0]});
            2'b10: expq.push_back({1'b1, er[1], d[15:8]});
            default: expq.push_back(10'h000);
        endcase
    endtask

    // Called at a negedge; drives a word until taken, returns at a negedge
    task automatic drive(input logic [15:0] d, input logic [1:0] en,
                         input logic [1:0] er, input bit junk = 1'b0);
        in_d = d; in_en = en; in_er = er;
        while (!in_rdy) begin
            @(posedge clk); @(negedge clk);
        end
        model(d, en, er);
        @(posedge clk); @(negedge clk);
        if (en == 2'b11) begin
            // R5: pause for exactly one cycle after a two-lane word
            check(!in_rdy, "R5 ready low after pair", {31'd0, in_rdy}, 32'd0);
            if (junk) begin
                in_d = 16'hEEEE; in_en = 2'b11; in_er = 2'b11;
            end
            @(posedge clk); @(negedge clk);
            check(in_rdy, "R5 ready back high", {31'd0, in_rdy}, 32'd1);
        end
    endtask

    task automatic begin_case();
        @(negedge clk);
        trace.delete(); expq.delete(); rec = 1'b1;
    endtask

    task automatic end_case(input string req);
        drive(16'h0, 2'b00, 2'b00);
        drive(16'h0, 2'b00, 2'b00);
        rec = 1'b0;
        check(trace.size() >= expq.size(), {req, " trace length"}, trace.size(), expq.size());
        foreach (expq[i]) begin
            if (i < trace.size())
                check(trace[i] === expq[i], {req, " cycle ", $sformatf("%0d", i)}, trace[i], expq[i]);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(!out_en && !out_er, "R9 outputs idle in reset", {out_en, out_er}, 0);
        check(in_rdy, "R9 ready high in reset", in_rdy, 1);
        rst_n = 1'b1;
        drive(16'h0, 2'b00, 2'b00);
    endtask

    task automatic t_pairs();  // R1, R8, R6
        begin_case();
        drive(16'hB2A1, 2'b11, 2'b00);
        drive(16'hD4C3, 2'b11, 2'b00);
        drive(16'hF6E5, 2'b11, 2'b00);
        end_case("R1 R8 R6 pairs");
    endtask

    task automatic t_lower_end();  // R2, R6
        begin_case();
        drive(16'h2211, 2'b11, 2'b00);
        drive(16'h9933, 2'b01, 2'b00);
        drive(16'h5544, 2'b11, 2'b00);
        drive(16'h7766, 2'b01, 2'b10);
        end_case("R2 R6 lower-lane end");
    endtask

    task automatic t_upper_only();  // R3
        begin_case();
        drive(16'h8A7B, 2'b10, 2'b00);
        drive(16'h1C2D, 2'b10, 2'b11);
        end_case("R3 upper-only");
    endtask

    task automatic t_errors();  // R4
        begin_case();
        drive(16'h0102, 2'b11, 2'b01);
        drive(16'h0304, 2'b11, 2'b10);
        drive(16'h0506, 2'b11, 2'b11);
        drive(16'h0708, 2'b01, 2'b01);
        end_case("R4 error lanes");
    endtask

    task automatic t_stall_junk();  // R5
        begin_case();
        drive(16'h3C5A, 2'b11, 2'b00, 1'b1);
        drive(16'h6B7E, 2'b11, 2'b01, 1'b1);
        end_case("R5 ignored during stall");
    endtask

    task automatic t_gap();  // R7
        begin_case();
        drive(16'hAB12, 2'b11, 2'b11);
        drive(16'h0000, 2'b00, 2'b11);
        drive(16'hCD34, 2'b01, 2'b00);
        end_case("R7 frame gap");
    endtask

    task automatic t_reset_mid();  // R9
        @(negedge clk);
        in_d = 16'h5A5A; in_en = 2'b11; in_er = 2'b10;
        @(posedge clk); @(negedge clk);
        in_en = 2'b00; in_er = 2'b00;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(!out_en && !out_er, "R9 reset mid-word outputs", {out_en, out_er}, 0);
        check(in_rdy, "R9 reset mid-word ready", in_rdy, 1);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(!out_en, "R9 pending byte discarded", out_en, 0);
    endtask

    initial begin
        t_reset();
        t_pairs();
        t_lower_end();
        t_upper_only();
        t_errors();
        t_stall_junk();
        t_gap();
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule